// File: doc/BRIEF.md
# Closed-loop synthesizer frequency meter

This block estimates the frequency of an unknown digital signal by steering an internal numerically controlled oscillator until the oscillator runs at the same rate. The oscillator is an n-bit phase accumulator that adds a tuning word every clock. The top bit of the accumulator is used as a square wave. A comparator counts square-wave rising edges over a fixed number of rising edges of the unknown signal. From that count it decides whether the oscillator is faster or slower than the input.

A start pulse sets the tuning word to midscale. A binary search then runs, halving its step after every comparator verdict. Once the step has fallen to one, the block switches to tracking: each verdict moves the word by one count, so it swings in a narrow triangle around the true value. The tuning word is the reading. The output frequency is word × fclk / 2^n, and the resolution is fclk / 2^n.

Top module: `dds_freq_meter`

## Requirements
- R1: After reset, `fsw` is 0, `valid`, `done` and `dds_sq` are 0. Without a start pulse, `fsw` remains 0.
- R2: The accumulator adds `fsw` to itself modulo 2^ACC_W on every clock. `dds_sq` is bit ACC_W-1 of the accumulator.
- R3: The clock edge that samples `start` high sets `fsw` to 2^(ACC_W-1) and `valid` to 0.
- R4: `sig_in` passes through a two-flop synchronizer and a rising-edge detector. A verdict is issued after every WINDOW detected input edges, with the first window opening on the first detected edge after start. The verdict is "slower" when fewer than WINDOW square-wave rising edges were counted in the window, "faster" when more were counted, and "no change" when the count equals WINDOW.
- R5: In search, the step begins at 2^(ACC_W-2). It is added to `fsw` on "slower" and subtracted on "faster", and `fsw` changes only when a verdict arrives. The step halves after each verdict.
- R6: The verdict taken with step 1 ends the search. `done` is high for exactly one cycle, and `valid` rises in the same cycle and stays high.
- R7: In tracking, each verdict changes `fsw` by exactly +1, -1 or 0.
- R8: For an input tone produced by an identical accumulator running with word F, `fsw` is within ±2 of F at the end of the search and throughout tracking.
- R9: If `start` is sampled in the same cycle that a verdict reaches the controller, `start` wins. `fsw` returns to midscale, `valid` drops, and the verdict is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new measurement |
| sig_in | input | 1 | Unknown signal, asynchronous |
| fsw | output | ACC_W | Frequency setting word, which is the reading |
| dds_sq | output | 1 | Square-wave oscillator output (accumulator MSB) |
| valid | output | 1 | High while tracking after a completed search |
| done | output | 1 | One-cycle pulse at the end of the search |

## Verification
Two events can land on the same clock edge: a restart request and a comparator verdict arriving at the controller. The bench's cycle model knows when a verdict is registered. While the loop is tracking, the bench raises `start` exactly in that cycle and then expects midscale, a low `valid`, and no trace of the verdict. The same per-clock model also follows the final search verdict, where the step update and the mode change coincide.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_SEARCH = 2'd1,
    MODE_TRACK  = 2'd2
  } fm_mode_t;
endpackage

// File: rtl/fm_sync_edge.sv
module fm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/fm_dds_acc.sv
module fm_dds_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] tune,
  output logic         msb
);
  logic [W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + tune;
  end

  assign msb = phase[W-1];
endmodule

// File: rtl/fm_freq_cmp.sv
module fm_freq_cmp #(
  parameter int WINDOW = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic in_rise,
  input  logic dds_msb,
  output logic dec_vld,
  output logic dec_up,
  output logic dec_dn
);
  localparam int IW  = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam int DCW = $clog2(WINDOW) + 2;
  localparam logic [IW-1:0]  LAST_IN = IW'(WINDOW - 1);
  localparam logic [DCW-1:0] REF_CNT = DCW'(WINDOW);
  localparam logic [DCW-1:0] CNT_MAX = '1;

  logic           msb_q;
  logic           dds_rise;
  logic           armed;
  logic [IW-1:0]  in_cnt;
  logic [DCW-1:0] dds_cnt;
  logic [DCW-1:0] dds_next;

  assign dds_rise = dds_msb & ~msb_q;

  always_comb begin
    dds_next = dds_cnt;
    if (dds_rise && dds_cnt != CNT_MAX) dds_next = dds_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) msb_q <= 1'b0;
    else     msb_q <= dds_msb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      in_cnt  <= '0;
      dds_cnt <= '0;
      dec_vld <= 1'b0;
      dec_up  <= 1'b0;
      dec_dn  <= 1'b0;
    end else begin
      dec_vld <= 1'b0;
      dec_up  <= 1'b0;
      dec_dn  <= 1'b0;
      if (restart || !run) begin
        armed <= 1'b0;
      end else if (!armed) begin
        if (in_rise) begin
          armed   <= 1'b1;
          in_cnt  <= '0;
          dds_cnt <= '0;
        end
      end else if (in_rise) begin
        if (in_cnt == LAST_IN) begin
          dec_vld <= 1'b1;
          dec_up  <= (dds_next < REF_CNT);
          dec_dn  <= (dds_next > REF_CNT);
          in_cnt  <= '0;
          dds_cnt <= '0;
        end else begin
          in_cnt  <= in_cnt + 1'b1;
          dds_cnt <= dds_next;
        end
      end else begin
        dds_cnt <= dds_next;
      end
    end
  end
endmodule

// File: rtl/fm_sa_ctrl.sv
module fm_sa_ctrl
  import fm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         dec_vld,
  input  logic         dec_up,
  input  logic         dec_dn,
  output logic [W-1:0] fsw,
  output logic         valid,
  output logic         done,
  output fm_mode_t     mode
);
  localparam logic [W-1:0] HALF  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] QUART = HALF >> 1;
  localparam logic [W-1:0] ONE   = W'(1);
  localparam logic [W-1:0] TOP   = '1;

  logic [W-1:0] step;

  always_ff @(posedge clk) begin
    if (rst) begin
      fsw   <= '0;
      step  <= '0;
      valid <= 1'b0;
      done  <= 1'b0;
      mode  <= MODE_IDLE;
    end else begin
      done <= 1'b0;
      if (start) begin
        fsw   <= HALF;
        step  <= QUART;
        valid <= 1'b0;
        mode  <= MODE_SEARCH;
      end else if (dec_vld) begin
        case (mode)
          MODE_SEARCH: begin
            if (dec_up)      fsw <= fsw + step;
            else if (dec_dn) fsw <= fsw - step;
            if (step == ONE) begin
              mode  <= MODE_TRACK;
              valid <= 1'b1;
              done  <= 1'b1;
            end else begin
              step <= step >> 1;
            end
          end
          MODE_TRACK: begin
            if (dec_up && fsw != TOP)      fsw <= fsw + ONE;
            else if (dec_dn && fsw != ONE) fsw <= fsw - ONE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dds_freq_meter.sv
module dds_freq_meter
  import fm_pkg::*;
#(
  parameter int ACC_W       = 32,
  parameter int WINDOW      = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             sig_in,
  output logic [ACC_W-1:0] fsw,
  output logic             dds_sq,
  output logic             valid,
  output logic             done
);
  logic     in_rise;
  logic     dec_vld;
  logic     dec_up;
  logic     dec_dn;
  fm_mode_t mode;

  fm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(sig_in), .rise(in_rise)
  );

  fm_dds_acc #(.W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .tune(fsw), .msb(dds_sq)
  );

  fm_freq_cmp #(.WINDOW(WINDOW)) u_cmp (
    .clk(clk), .rst(rst), .run(mode != MODE_IDLE), .restart(start),
    .in_rise(in_rise), .dds_msb(dds_sq),
    .dec_vld(dec_vld), .dec_up(dec_up), .dec_dn(dec_dn)
  );

  fm_sa_ctrl #(.W(ACC_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .dec_vld(dec_vld), .dec_up(dec_up), .dec_dn(dec_dn),
    .fsw(fsw), .valid(valid), .done(done), .mode(mode)
  );
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] fsw,
  input logic         valid,
  input logic         done,
  input logic         dec_vld,
  input logic         dec_up,
  input logic         dec_dn
);
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  AST_START_MIDSCALE: assert property (@(posedge clk) disable iff (rst)
    start |=> (fsw == HALF && !valid)); // R3

  AST_VERDICT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dec_up, dec_dn})); // R4

  AST_HOLD_WITHOUT_VERDICT: assert property (@(posedge clk) disable iff (rst)
    (!dec_vld && !start) |=> $stable(fsw)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> done); // R6

  AST_TRACK_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (valid && !start) |=> (fsw == $past(fsw) || fsw == $past(fsw) + 1'b1 ||
                           fsw == $past(fsw) - 1'b1)); // R7

  AST_TRACK_NONZERO: assert property (@(posedge clk) disable iff (rst)
    valid |-> (fsw != '0)); // R7
endmodule

bind dds_freq_meter fm_checker #(.W(ACC_W)) u_fm_checker (
  .clk(clk), .rst(rst), .start(start), .fsw(fsw), .valid(valid), .done(done),
  .dec_vld(dec_vld), .dec_up(dec_up), .dec_dn(dec_dn)
);

// File: tb/dds_freq_meter_bench.sv
module dds_freq_meter_bench;
  localparam int N = 10;
  localparam int K = 256;
  localparam int HALF = 1 << (N-1);
  localparam int MASK = (1 << N) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic sig_in = 1'b0;
  logic [N-1:0] fsw;
  logic dds_sq, valid, done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int ref_fsw = 100;
  int ref_acc = 0;

  always #5 clk = ~clk;

  dds_freq_meter #(.ACC_W(N), .WINDOW(K), .SYNC_STAGES(2)) u_dds_freq_meter (
    .clk(clk), .rst(rst), .start(start), .sig_in(sig_in),
    .fsw(fsw), .dds_sq(dds_sq), .valid(valid), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      if (fails < 20) $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // input tone from a reference accumulator, driven away from the active edge
  initial forever begin
    @(negedge clk);
    ref_acc = (ref_acc + ref_fsw) & MASK;
    sig_in = ((ref_acc >> (N-1)) & 1) != 0;
  end

  // behavioural cycle model
  int m_s1, m_s2, m_s3, m_acc, m_prev, m_armed, m_in, m_dcnt;
  int m_dv, m_up, m_dn, m_mode, m_fsw, m_step, m_valid, m_done;
  int t_rise, t_msb, t_drise, t_d;
  int o_dv, o_up, o_dn;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_acc = 0; m_prev = 0; m_armed = 0;
      m_in = 0; m_dcnt = 0; m_dv = 0; m_up = 0; m_dn = 0; m_mode = 0;
      m_fsw = 0; m_step = 0; m_valid = 0; m_done = 0;
    end else begin
      t_rise = (m_s2 == 1 && m_s3 == 0);
      t_msb = (m_acc >> (N-1)) & 1;
      t_drise = (t_msb == 1 && m_prev == 0);
      o_dv = m_dv; o_up = m_up; o_dn = m_dn;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sig_in;
      m_acc = (m_acc + m_fsw) & MASK;
      m_prev = t_msb;
      // comparator (decided from the mode before this edge)
      m_dv = 0; m_up = 0; m_dn = 0;
      if (start || m_mode == 0) m_armed = 0;
      else if (m_armed == 0) begin
        if (t_rise) begin m_armed = 1; m_in = 0; m_dcnt = 0; end
      end else begin
        t_d = m_dcnt + t_drise;
        if (t_rise) begin
          if (m_in + 1 == K) begin
            m_dv = 1; m_up = (t_d < K); m_dn = (t_d > K);
            m_in = 0; m_dcnt = 0;
          end else begin
            m_in++; m_dcnt = t_d;
          end
        end else m_dcnt = t_d;
      end
      // controller
      m_done = 0;
      if (start) begin
        m_fsw = HALF; m_step = HALF / 2; m_valid = 0; m_mode = 1;
      end else if (o_dv && m_mode == 1) begin
        if (o_up) m_fsw += m_step;
        else if (o_dn) m_fsw -= m_step;
        if (m_step == 1) begin m_mode = 2; m_valid = 1; m_done = 1; end
        else m_step = m_step / 2;
      end else if (o_dv && m_mode == 2) begin
        if (o_up && m_fsw < MASK) m_fsw++;
        else if (o_dn && m_fsw > 1) m_fsw--;
      end
    end
  end

  // per-clock comparison with the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(int'(fsw) == m_fsw, "R5/R7 fsw vs model", int'(fsw), m_fsw);
      chk(int'(dds_sq) == ((m_acc >> (N-1)) & 1), "R2 dds_sq vs model", int'(dds_sq), (m_acc >> (N-1)) & 1);
      chk(int'(valid) == m_valid, "R6 valid vs model", int'(valid), m_valid);
      chk(int'(done) == m_done, "R6 done vs model", int'(done), m_done);
    end
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 60000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
  endtask

  task automatic hold_window(input int n, input int target, input string req);
    bit ok = 1;
    int worst = target;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (int'(fsw) > target + 2 || int'(fsw) < target - 2) begin ok = 0; worst = int'(fsw); end
    end
    chk(ok, req, worst, target);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        fails++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    bit seen;
    int first;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(fsw == 0 && !valid && !done && !dds_sq, "R1 reset state", int'(fsw), 0);
    repeat (50) @(negedge clk);
    chk(fsw == 0 && !dds_sq, "R1 idle without start", int'(fsw), 0);

    // tone 1
    pulse_start();
    chk(int'(fsw) == HALF && !valid, "R3 midscale after start", int'(fsw), HALF);
    first = HALF;
    for (int i = 0; i < 20000 && first == HALF; i++) begin
      @(negedge clk);
      first = int'(fsw);
    end
    chk(first == HALF - HALF/2, "R4 R5 first search step (dds faster)", first, HALF - HALF/2);
    wait_done(seen);
    chk(seen, "R6 search completes", int'(seen), 1);
    chk(valid == 1'b1, "R6 valid with done", int'(valid), 1);
    chk(int'(fsw) <= ref_fsw + 2 && int'(fsw) + 2 >= ref_fsw, "R8 estimate tone 1", int'(fsw), ref_fsw);
    @(negedge clk);
    chk(!done && valid, "R6 done single cycle", int'(done), 0);
    hold_window(30000, ref_fsw, "R8 R7 tracking band tone 1");

    // restart colliding with a verdict during tracking
    ref_fsw = 150;
    for (int i = 0; i < 20000 && m_dv == 0; i++) @(negedge clk);
    chk(m_dv == 1, "R9 verdict cycle found", m_dv, 1);
    pulse_start();
    chk(int'(fsw) == HALF && !valid, "R9 start wins over verdict", int'(fsw), HALF);
    wait_done(seen);
    chk(seen, "R6 search completes tone 2", int'(seen), 1);
    chk(int'(fsw) <= ref_fsw + 2 && int'(fsw) + 2 >= ref_fsw, "R8 estimate tone 2", int'(fsw), ref_fsw);
    hold_window(14000, ref_fsw, "R8 R7 tracking band tone 2");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule